// File: doc/BRIEF.md
# Closed Caption Line Waveform Encoder

This block produces the caption and extended-data waveform for a single video line. It runs one sample per 27 MHz clock. The host stores four bytes through a small write port: a low byte and a high byte for the caption service, and the same pair for the extended-data service. The video timing supplies a line number and a horizontal sample position. On the line that belongs to an enabled service, the block emits a fixed sequence at a programmable high level: a clock run-in, three start bits and sixteen data bits. The luma path adds this level to its own signal.

Each service has its own ready flag, and the host uses it as a handshake. Writing the high byte of a pair marks that pair as renewed and drops the flag. Once the renewed pair has gone out on its line, the flag rises again. A line that arrives with no renewed pair carries a NULL character pair. Parity is never computed here: each byte is sent exactly as written.

Top module: `cc_line_encoder`

## Requirements
- R1: After reset, `level_out` is 0 and both `cap_ready` and `ext_ready` are 1.
- R2: The caption waveform appears only on line 21, and this holds in both line systems. The extended-data waveform appears on line 284 when `std_625`=0 and on line 334 when `std_625`=1. On every other line `level_out` stays 0.
- R3: When a service's enable is low, its line stays at 0. Its pending pair and its ready flag are left as they were, so the pair is sent on the first enabled line that follows.
- R4: The waveform is 52 half-bit slots long. Slots 0..13 form the run-in and alternate high and low, starting high. Slots 14..19 hold the start bits 0,0,1, two slots per bit. Slots 20..51 hold 16 data bits, two slots per bit. The data bits go LSB first: first the low byte (address 0 for caption, address 2 for extended), then the high byte (address 1 or 3).
- R5: Sample n=0 appears in the clock after the edge at which `hpos` equals 284. Sample n belongs to slot floor(n*2445/65536). After slot 51, `level_out` returns to 0.
- R6: A high slot outputs the value of `hi_level` from the previous clock. A low slot outputs 0.
- R7: A pair counts as renewed only when its high byte (address 1 or 3) is written. Writing only the low byte does not renew the pair.
- R8: A line that finds no renewed pair for its service sends the NULL pair 0x80, 0x80. A renewed pair is sent exactly once.
- R9: Bytes are sent verbatim, including bit 7, whether or not the parity is odd.
- R10: A high-byte write clears that service's ready flag in the next clock. The flag is set again after that service's waveform ends, provided no newer high-byte write is pending.
- R11: Suppose a high-byte write lands in the same clock as the line start of that service. The line then carries the pair as it stood before the write. The new pair remains pending for the next matching line, and the ready flag stays 0 until that line has been sent.
- R12: Writes made while a waveform is in flight do not change that waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select: 0/1 caption low/high, 2/3 extended low/high |
| wr_data | input | 8 | Byte value, parity in bit 7 |
| cap_en | input | 1 | Caption insertion enable |
| ext_en | input | 1 | Extended-data insertion enable |
| std_625 | input | 1 | 1 selects 625-line numbering for extended data |
| line_num | input | 10 | Current line number |
| hpos | input | 11 | Sample position within the line |
| hi_level | input | 8 | Code used for a high slot |
| level_out | output | 8 | Waveform level code, 0 at blank |
| cap_ready | output | 1 | Caption service accepts a new pair |
| ext_ready | output | 1 | Extended service accepts a new pair |

## Verification
Two events can land in the same clock: the host's high-byte write and the line-start latch of the same service. The bench forces this overlap by issuing the caption high-byte write exactly when `hpos` reaches the start position on line 21. The result is judged in three places. The in-flight line must carry the old pair. `cap_ready` must still be 0 after that line. The following caption line must carry the new pair and then raise the flag. A second case places a write in the middle of a transmission, to show that the running waveform stays frozen.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;

  localparam int RUNIN_SLOTS = 14;
  localparam int TOTAL_SLOTS = 52;
  localparam int SLOT_W      = 6;
  localparam int PAIR_W      = 16;
  localparam logic [7:0] NULL_CODE = 8'h80;

  typedef enum logic {SVC_CAP = 1'b0, SVC_EXT = 1'b1} svc_e;

  // Level of one half-bit slot: run-in, start bits, then data LSB first.
  function automatic logic slot_bit(input logic [SLOT_W-1:0] slot,
                                    input logic [PAIR_W-1:0] word);
    logic [4:0] bitno;
    logic [3:0] di;
    bitno = slot[SLOT_W-1:1];
    di    = 4'(bitno - 5'd10);
    if (slot < SLOT_W'(RUNIN_SLOTS)) return ~slot[0];
    else if (bitno < 5'd9)           return 1'b0;
    else if (bitno == 5'd9)          return 1'b1;
    else                             return word[di];
  endfunction

endpackage

// File: rtl/cc_host_regs.sv
module cc_host_regs #(
  parameter int BYTE_W = 8,
  localparam int NSVC  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load,
  input  logic              load_svc,
  input  logic              done,
  input  logic              done_svc,
  output logic [2*BYTE_W-1:0] pair_word,
  output logic [NSVC-1:0]   rdy
);
  import cc_enc_pkg::*;

  logic [BYTE_W-1:0] mem [4];
  logic [NSVC-1:0]   pend;
  logic              hi_wr;

  assign hi_wr = wr_en & wr_addr[0];

  // plain storage without reset so it maps to small RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  for (genvar s = 0; s < NSVC; s++) begin : g_svc
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[s] <= 1'b0;
        rdy[s]  <= 1'b1;
      end else if (hi_wr && wr_addr[1] == 1'(s)) begin
        pend[s] <= 1'b1;
        rdy[s]  <= 1'b0;
      end else begin
        if (load && load_svc == 1'(s)) pend[s] <= 1'b0;
        if (done && done_svc == 1'(s) && !pend[s]) rdy[s] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (pend[load_svc])
      pair_word = {mem[{load_svc, 1'b1}], mem[{load_svc, 1'b0}]};
    else
      pair_word = {BYTE_W'(NULL_CODE), BYTE_W'(NULL_CODE)};
  end

endmodule

// File: rtl/cc_bit_clock.sv
module cc_bit_clock #(
  parameter int ACC_W   = 16,
  parameter int INC     = 2445,
  parameter int NSLOT   = 52,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              running,
  output logic [SLOT_W-1:0] slot,
  output logic              done
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + (ACC_W+1)'(INC);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      acc     <= '0;
      slot    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running <= 1'b1;
        acc     <= '0;
        slot    <= '0;
      end else if (running) begin
        acc <= sum[ACC_W-1:0];
        if (sum[ACC_W]) begin
          if (slot == SLOT_W'(NSLOT-1)) begin
            running <= 1'b0;
            done    <= 1'b1;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/cc_wave_gen.sv
module cc_wave_gen #(
  parameter int LEVEL_W = 8,
  parameter int PAIR_W  = 16,
  parameter int SLOT_W  = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PAIR_W-1:0]  word_in,
  input  logic               running,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [LEVEL_W-1:0] hi_level,
  output logic [LEVEL_W-1:0] level_out
);
  import cc_enc_pkg::*;

  logic [PAIR_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      level_out <= '0;
    end else begin
      if (load) word_q <= word_in;
      level_out <= (running && slot_bit(slot, word_q)) ? hi_level : '0;
    end
  end

endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder #(
  parameter int LINE_W      = 10,
  parameter int HPOS_W      = 11,
  parameter int LEVEL_W     = 8,
  parameter int START_POS   = 284,
  parameter int CAP_LINE    = 21,
  parameter int EXT_LINE_A  = 284,
  parameter int EXT_LINE_B  = 334,
  parameter int ACC_W       = 16,
  parameter int SLOT_INC    = 2445
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               cap_en,
  input  logic               ext_en,
  input  logic               std_625,
  input  logic [LINE_W-1:0]  line_num,
  input  logic [HPOS_W-1:0]  hpos,
  input  logic [LEVEL_W-1:0] hi_level,
  output logic [LEVEL_W-1:0] level_out,
  output logic               cap_ready,
  output logic               ext_ready
);
  import cc_enc_pkg::*;

  localparam int BYTE_W = PAIR_W / 2;

  logic [LINE_W-1:0] ext_line;
  logic              cap_hit, ext_hit, start;
  logic              running, done;
  logic [SLOT_W-1:0] slot;
  logic [PAIR_W-1:0] pair_word;
  logic [1:0]        rdy;
  svc_e              cur_svc;
  svc_e              new_svc;

  assign ext_line = std_625 ? LINE_W'(EXT_LINE_B) : LINE_W'(EXT_LINE_A);
  assign cap_hit  = cap_en && (line_num == LINE_W'(CAP_LINE));
  assign ext_hit  = ext_en && (line_num == ext_line);
  assign start    = !running && (hpos == HPOS_W'(START_POS)) && (cap_hit || ext_hit);
  assign new_svc  = ext_hit ? SVC_EXT : SVC_CAP;

  always_ff @(posedge clk) begin
    if (rst)        cur_svc <= SVC_CAP;
    else if (start) cur_svc <= new_svc;
  end

  cc_host_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(start), .load_svc(new_svc),
    .done(done), .done_svc(cur_svc),
    .pair_word(pair_word), .rdy(rdy)
  );

  cc_bit_clock #(.ACC_W(ACC_W), .INC(SLOT_INC), .NSLOT(TOTAL_SLOTS)) u_clk (
    .clk(clk), .rst(rst), .start(start),
    .running(running), .slot(slot), .done(done)
  );

  cc_wave_gen #(.LEVEL_W(LEVEL_W), .PAIR_W(PAIR_W), .SLOT_W(SLOT_W)) u_wave (
    .clk(clk), .rst(rst), .load(start), .word_in(pair_word),
    .running(running), .slot(slot), .hi_level(hi_level),
    .level_out(level_out)
  );

  assign cap_ready = rdy[SVC_CAP];
  assign ext_ready = rdy[SVC_EXT];

endmodule

// File: rtl/cc_line_encoder_chk.sv
module cc_line_encoder_chk #(
  parameter int LINE_W     = 10,
  parameter int HPOS_W     = 11,
  parameter int LEVEL_W    = 8,
  parameter int START_POS  = 284,
  parameter int CAP_LINE   = 21,
  parameter int EXT_LINE_A = 284,
  parameter int EXT_LINE_B = 334
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [1:0]         wr_addr,
  input logic               cap_en,
  input logic               ext_en,
  input logic               std_625,
  input logic [LINE_W-1:0]  line_num,
  input logic [HPOS_W-1:0]  hpos,
  input logic [LEVEL_W-1:0] hi_level,
  input logic [LEVEL_W-1:0] level_out,
  input logic               cap_ready,
  input logic               ext_ready
);

  // R10
  cap_rdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cap_ready) |-> $past(wr_en && wr_addr == 2'd1));

  // R10
  cap_rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_ready) |-> !$past(wr_en && wr_addr == 2'd1));

  // R10
  ext_rdy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_ready) |-> $past(wr_en && wr_addr == 2'd3));

  // R10
  ext_rdy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_ready) |-> !$past(wr_en && wr_addr == 2'd3));

  // R6
  level_code_chk: assert property (@(posedge clk) disable iff (rst)
    level_out == '0 || level_out == $past(hi_level));

  // R5
  early_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hpos) <= HPOS_W'(START_POS)) |-> level_out == '0);

  // R2
  line_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(hpos) == HPOS_W'(START_POS + 1) && level_out != '0) |->
      (($past(cap_en, 2) && $past(line_num, 2) == LINE_W'(CAP_LINE)) ||
       ($past(ext_en, 2) && !$past(std_625, 2) && $past(line_num, 2) == LINE_W'(EXT_LINE_A)) ||
       ($past(ext_en, 2) &&  $past(std_625, 2) && $past(line_num, 2) == LINE_W'(EXT_LINE_B))));

endmodule

bind cc_line_encoder cc_line_encoder_chk #(
  .LINE_W(LINE_W), .HPOS_W(HPOS_W), .LEVEL_W(LEVEL_W), .START_POS(START_POS),
  .CAP_LINE(CAP_LINE), .EXT_LINE_A(EXT_LINE_A), .EXT_LINE_B(EXT_LINE_B)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .cap_en(cap_en), .ext_en(ext_en), .std_625(std_625),
  .line_num(line_num), .hpos(hpos), .hi_level(hi_level),
  .level_out(level_out), .cap_ready(cap_ready), .ext_ready(ext_ready)
);

// File: tb/sim_cc_line_encoder.sv
module sim_cc_line_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_LEN   = 1716;
  localparam int START      = 284;
  localparam int INC        = 2445;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cap_en = 1'b0, ext_en = 1'b0, std_625 = 1'b0;
  logic [9:0]  line_num = '0;
  logic [10:0] hpos = '0;
  logic [7:0]  hi_level = 8'hA0;
  logic [7:0]  level_out;
  logic        cap_ready, ext_ready;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cc_line_encoder u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_en(cap_en), .ext_en(ext_en), .std_625(std_625),
    .line_num(line_num), .hpos(hpos), .hi_level(hi_level),
    .level_out(level_out), .cap_ready(cap_ready), .ext_ready(ext_ready)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_level(input int n, input logic [15:0] w, input bit on,
                                           input logic [7:0] hi);
    int s, b;
    bit v;
    if (!on || n < 0) return 8'h00;
    s = int'((longint'(n) * INC) >>> 16);
    if (s >= 52) return 8'h00;
    b = s / 2;
    if (s < 14)       v = (s % 2 == 0);
    else if (b < 9)   v = 1'b0;
    else if (b == 9)  v = 1'b1;
    else              v = w[b-10];
    return v ? hi : 8'h00;
  endfunction

  task automatic write_byte(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode 1: caption high-byte write at the start sample; mode 2: same write mid-waveform
  task automatic run_line(input int ln, input logic [15:0] w, input bit on, input int mode,
                          input logic [7:0] mdata, input string req);
    int bad = 0;
    int bad_got = 0, bad_exp = 0;
    logic [7:0] e;
    line_num = 10'(ln);
    for (int h = 0; h < LINE_LEN; h++) begin
      hpos  = 11'(h);
      wr_en = 1'b0;
      if ((mode == 1 && h == START) || (mode == 2 && h == START + 300)) begin
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = mdata;
      end
      @(posedge clk); @(negedge clk);
      e = exp_level(h - START - 1, w, on, hi_level);
      if (level_out !== e) begin
        if (bad == 0) begin bad_got = int'(level_out); bad_exp = int'(e); end
        bad++;
      end
    end
    wr_en = 1'b0;
    hpos  = '0;
    check(bad == 0, req, bad_got, bad_exp);
  endtask

  task automatic t_reset;
    check(level_out == 8'h00, "R1 level", int'(level_out), 0);
    check(cap_ready && ext_ready, "R1 ready", int'({cap_ready, ext_ready}), 3);
  endtask

  task automatic t_null_and_data;
    cap_en = 1'b1;
    run_line(21, 16'h8080, 1, 0, 0, "R8 null pair on idle line");
    check(cap_ready == 1'b1, "R10 ready after null", int'(cap_ready), 1);
    write_byte(2'd0, 8'hC1);
    check(cap_ready == 1'b1, "R7 low byte keeps ready", int'(cap_ready), 1);
    write_byte(2'd1, 8'hC2);
    check(cap_ready == 1'b0, "R10 ready cleared", int'(cap_ready), 0);
    run_line(21, 16'hC2C1, 1, 0, 0, "R4 R5 waveform of caption pair");
    check(cap_ready == 1'b1, "R10 ready set after line", int'(cap_ready), 1);
    run_line(21, 16'h8080, 1, 0, 0, "R8 pair sent once");
  endtask

  task automatic t_low_only;
    write_byte(2'd0, 8'h55);
    run_line(21, 16'h8080, 1, 0, 0, "R7 low byte alone not renewed");
  endtask

  task automatic t_other_line;
    write_byte(2'd1, 8'h33);
    run_line(20, 16'h3355, 0, 0, 0, "R2 line 20 silent");
    check(cap_ready == 1'b0, "R2 ready held on other line", int'(cap_ready), 0);
    run_line(21, 16'h3355, 1, 0, 0, "R2 caption on line 21");
  endtask

  task automatic t_parity;
    write_byte(2'd0, 8'h01);
    write_byte(2'd1, 8'h03);
    run_line(21, 16'h0301, 1, 0, 0, "R9 bytes verbatim");
  endtask

  task automatic t_level;
    hi_level = 8'h68;
    write_byte(2'd0, 8'hC1);
    write_byte(2'd1, 8'hC2);
    run_line(21, 16'hC2C1, 1, 0, 0, "R6 programmed high level");
    hi_level = 8'hA0;
  endtask

  task automatic t_disable;
    cap_en = 1'b0;
    write_byte(2'd0, 8'h2A);
    write_byte(2'd1, 8'hAB);
    run_line(21, 16'hAB2A, 0, 0, 0, "R3 disabled line silent");
    check(cap_ready == 1'b0, "R3 ready kept while disabled", int'(cap_ready), 0);
    cap_en = 1'b1;
    run_line(21, 16'hAB2A, 1, 0, 0, "R3 pending pair sent after enable");
  endtask

  task automatic t_ext;
    ext_en = 1'b1; std_625 = 1'b0;
    write_byte(2'd2, 8'h8F);
    write_byte(2'd3, 8'h70);
    check(ext_ready == 1'b0, "R10 ext ready cleared", int'(ext_ready), 0);
    run_line(334, 16'h708F, 0, 0, 0, "R2 line 334 silent in 525");
    run_line(284, 16'h708F, 1, 0, 0, "R2 extended on 284");
    check(ext_ready == 1'b1, "R10 ext ready set", int'(ext_ready), 1);
    std_625 = 1'b1;
    write_byte(2'd2, 8'h4C);
    write_byte(2'd3, 8'hE3);
    run_line(284, 16'hE34C, 0, 0, 0, "R2 line 284 silent in 625");
    run_line(334, 16'hE34C, 1, 0, 0, "R2 extended on 334");
    run_line(21, 16'h8080, 1, 0, 0, "R2 caption line 21 in 625");
    std_625 = 1'b0;
  endtask

  task automatic t_collide;
    write_byte(2'd0, 8'hC1);
    write_byte(2'd1, 8'hC2);
    run_line(21, 16'hC2C1, 1, 1, 8'h54, "R11 line keeps prior pair");
    check(cap_ready == 1'b0, "R11 ready low after colliding write", int'(cap_ready), 0);
    run_line(21, 16'h54C1, 1, 0, 0, "R11 new pair on next line");
    check(cap_ready == 1'b1, "R11 ready after new pair", int'(cap_ready), 1);
  endtask

  task automatic t_midwrite;
    write_byte(2'd1, 8'h9E);
    run_line(21, 16'h9EC1, 1, 2, 8'h6D, "R12 waveform frozen during write");
    check(cap_ready == 1'b0, "R12 ready low with pending write", int'(cap_ready), 0);
    run_line(21, 16'h6DC1, 1, 0, 0, "R12 later write sent next");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_null_and_data();
    t_low_only();
    t_other_line();
    t_parity();
    t_level();
    t_disable();
    t_ext();
    t_collide();
    t_midwrite();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule